// File: doc/BRIEF.md
# Virtual Timer Offset Register Bank

This block holds one 64-bit offset per timer frame, up to eight frames. Each offset is the amount by which virtual time trails real time for its frame. Software reaches the offsets through a simple request/response register port. An offset can be read or written as two 32-bit words, or as one indivisible 64-bit word when wide access is enabled. Each write carries byte strobes, and only the enabled bytes change.

Each access is filtered by its security state. Secure requests always reach a slot that is built in. A non-secure request reaches slot n only while permit bit n is set. A slot that is blocked, a slot that is not built, an address outside the window and a misaligned address all read as zero and ignore writes. None of these cases signals an error.

Besides the bus view, the block outputs every offset in parallel. It also outputs a registered virtual count for each frame, which is the shared physical count minus that frame's offset. The physical count, frame enables and bus fabric are outside the block.

Top module: `tob_offset_bank`

## Requirements
- R1: A 32-bit access to slot n uses byte address 0x080+8n for offset bits [31:0] and 0x084+8n for bits [63:32]. A 32-bit read returns the word in rsp_rdata[31:0], with rsp_rdata[63:32] equal to zero.
- R2: A 64-bit access (req_wide=1) at 0x080+8n reads or writes all 64 bits of slot n in a single request. The whole value changes on one clock edge.
- R3: A write changes only the bytes whose strobe is set. A 32-bit access uses req_wstrb[3:0] (bit b maps to byte b of the addressed word) and ignores req_wstrb[7:4]. A 64-bit access uses req_wstrb[7:0] (bit b maps to offset byte b).
- R4: A secure request (req_secure=1) can always read and write a slot that is built in.
- R5: A non-secure request to slot n while ns_permit[n]=0 reads as zero, leaves the offset unchanged and raises no error.
- R6: A non-secure request to slot n while ns_permit[n]=1 reads and writes the slot as a secure request would.
- R7: A slot whose IMPL_MASK bit is 0 reads as zero, ignores writes and drives zero on its offset_out lane.
- R8: Each of the following reads as zero and changes no offset: an address below 0x080, an address at or above 0x080+8*NUM_SLOTS, a 32-bit access whose address is not a multiple of 4, and a 64-bit access whose address is not a multiple of 8.
- R9: virt_count_out lane n equals phys_count minus offset n, modulo 2^64. The value is registered, so it reflects the inputs one clock earlier.
- R10: offset_out lane n (bits [64n+63:64n]) shows slot n's stored offset. The lane updates on the edge that accepts a write.
- R11: rsp_valid is high exactly one cycle after each cycle in which req_valid is high. A write response carries rsp_rdata equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_secure | input | 1 | 1 = secure request |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data (32-bit accesses use [31:0]) |
| req_wstrb | input | 8 | Byte strobes |
| ns_permit | input | NUM_SLOTS | Per-slot non-secure permit |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| phys_count | input | 64 | Shared physical count |
| offset_out | output | 64*NUM_SLOTS | All stored offsets, slot n in lane n |
| virt_count_out | output | 64*NUM_SLOTS | Per-slot virtual count |

## Verification
The bench writes a partial strobe to the upper word of a slot. A design that steers lanes wrongly would damage the lower word or move bytes. The bench sends non-secure writes to a slot whose permit bit is clear, then reads the slot back through a secure read. A design that checked only reads would change the slot. It also probes a misaligned wide access, the first address past the window and a slot that is not built, each of which must read zero and leave every offset unchanged. Finally, it drives phys_count below an offset so the virtual count must wrap. A design with a truncated or saturating subtractor would show a wrong lane there.

// File: rtl/tob_pkg.sv
package tob_pkg;
   localparam int TOB_MAX_SLOTS = 8;
   localparam int TOB_WORD_W    = 64;

   typedef logic [TOB_WORD_W-1:0] tob_word_t;
   typedef logic [2:0]            tob_idx_t;

   typedef struct packed {
      logic     ok;     // access fully permitted
      logic     upper;  // 32-bit access targets bits [63:32]
      tob_idx_t idx;    // slot index
   } tob_dec_t;
endpackage

// File: rtl/tob_decode.sv
module tob_decode
   import tob_pkg::*;
#(
   parameter int                   ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]    BASE_ADDR = 'h080,
   parameter int                   NUM_SLOTS = 8,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = '1,
   parameter bit                   ATOMIC64  = 1'b1
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wide,
   input  logic                 secure,
   input  logic [NUM_SLOTS-1:0] ns_permit,
   output tob_dec_t             dec
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(8 * NUM_SLOTS);

   logic [ADDR_W-1:0] rel;
   logic in_win, aligned, width_ok, present, permitted;
   tob_idx_t idx;

   always_comb begin
      rel       = addr - BASE_ADDR;
      in_win    = (addr >= BASE_ADDR) && (rel < SPAN);
      aligned   = wide ? (rel[2:0] == 3'd0) : (rel[1:0] == 2'd0);
      width_ok  = !wide || ATOMIC64;
      idx       = rel[5:3];
      present   = IMPL_MASK[idx];
      permitted = secure || ns_permit[idx];
      dec.ok    = in_win && aligned && width_ok && present && permitted;
      dec.upper = rel[2];
      dec.idx   = idx;
   end
endmodule

// File: rtl/tob_slot.sv
module tob_slot
   import tob_pkg::*;
#(
   parameter bit IMPLEMENTED = 1'b1
) (
   input  logic      clk,
   input  logic      wr_en,
   input  logic [7:0] lane_strb,
   input  tob_word_t lane_data,
   output tob_word_t value
);
   generate
      if (IMPLEMENTED) begin : g_store
         tob_word_t store_q;
         always_ff @(posedge clk) begin
            if (wr_en) begin
               for (int b = 0; b < 8; b++) begin
                  if (lane_strb[b]) store_q[8*b +: 8] <= lane_data[8*b +: 8];
               end
            end
         end
         assign value = store_q;
      end else begin : g_absent
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, wr_en, lane_strb, lane_data};
         assign value     = '0;
      end
   endgenerate
endmodule

// File: rtl/tob_vcount.sv
module tob_vcount
   import tob_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  tob_word_t phys,
   input  tob_word_t offset,
   output tob_word_t vcount
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vcount <= '0;
      else        vcount <= phys - offset;
   end
endmodule

// File: rtl/tob_offset_bank.sv
module tob_offset_bank
   import tob_pkg::*;
#(
   parameter int                   ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]    BASE_ADDR = 'h080,
   parameter int                   NUM_SLOTS = 8,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = '1,
   parameter bit                   ATOMIC64  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic                      req_wide,
   input  logic                      req_secure,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [63:0]               req_wdata,
   input  logic [7:0]                req_wstrb,
   input  logic [NUM_SLOTS-1:0]      ns_permit,
   output logic                      rsp_valid,
   output logic [63:0]               rsp_rdata,
   input  logic [63:0]               phys_count,
   output logic [64*NUM_SLOTS-1:0]   offset_out,
   output logic [64*NUM_SLOTS-1:0]   virt_count_out
);
   initial begin
      assert (NUM_SLOTS >= 1 && NUM_SLOTS <= TOB_MAX_SLOTS)
         else $error("NUM_SLOTS out of range");
      assert (BASE_ADDR[5:0] == 6'd0)
         else $error("BASE_ADDR must be 64-byte aligned");
      assert (ADDR_W >= 7) else $error("ADDR_W too small");
   end

   tob_dec_t  dec;
   logic [7:0] lane_strb;
   tob_word_t lane_data;
   tob_word_t slot_val [NUM_SLOTS];
   tob_word_t sel, rd_next;

   tob_decode #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_SLOTS(NUM_SLOTS),
      .IMPL_MASK(IMPL_MASK), .ATOMIC64(ATOMIC64)
   ) decode_i (
      .addr(req_addr), .wide(req_wide), .secure(req_secure),
      .ns_permit(ns_permit), .dec(dec)
   );

   // Steer a 32-bit word onto the half of the 64-bit slot it addresses.
   always_comb begin
      if (req_wide) begin
         lane_strb = req_wstrb;
         lane_data = req_wdata;
      end else begin
         lane_strb = dec.upper ? {req_wstrb[3:0], 4'b0000} : {4'b0000, req_wstrb[3:0]};
         lane_data = {req_wdata[31:0], req_wdata[31:0]};
      end
   end

   genvar n;
   generate
      for (n = 0; n < NUM_SLOTS; n++) begin : g_slot
         logic wr_hit;
         assign wr_hit = req_valid && req_write && dec.ok && (dec.idx == tob_idx_t'(n));

         tob_slot #(.IMPLEMENTED(IMPL_MASK[n])) slot_i (
            .clk(clk), .wr_en(wr_hit), .lane_strb(lane_strb),
            .lane_data(lane_data), .value(slot_val[n])
         );

         tob_vcount vcount_i (
            .clk(clk), .rst_n(rst_n), .phys(phys_count), .offset(slot_val[n]),
            .vcount(virt_count_out[64*n +: 64])
         );

         assign offset_out[64*n +: 64] = slot_val[n];
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (dec.idx == tob_idx_t'(i)) sel = slot_val[i];
      end
      if (!dec.ok || req_write) rd_next = '0;
      else if (req_wide)        rd_next = sel;
      else                      rd_next = {32'd0, dec.upper ? sel[63:32] : sel[31:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= req_valid ? rd_next : 64'd0;
      end
   end
endmodule

// File: rtl/tob_offset_bank_chk.sv
module tob_offset_bank_chk #(
   parameter int                   ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]    BASE_ADDR = 'h080,
   parameter int                   NUM_SLOTS = 8,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = '1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_write,
   input logic                    req_wide,
   input logic                    req_secure,
   input logic [ADDR_W-1:0]       req_addr,
   input logic [NUM_SLOTS-1:0]    ns_permit,
   input logic                    rsp_valid,
   input logic [63:0]             rsp_rdata,
   input logic [63:0]             phys_count,
   input logic [64*NUM_SLOTS-1:0] offset_out,
   input logic [64*NUM_SLOTS-1:0] virt_count_out
);
   logic [ADDR_W-1:0] c_rel;
   logic c_win, c_misal;
   logic [2:0] c_idx;
   assign c_rel   = req_addr - BASE_ADDR;
   assign c_win   = (req_addr >= BASE_ADDR) && (c_rel < ADDR_W'(8 * NUM_SLOTS));
   assign c_misal = req_wide ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0);
   assign c_idx   = c_rel[5:3];

   assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_write_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 64'd0));
   assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_wide) |=> (rsp_rdata[63:32] == 32'd0));
   assert_ns_read_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_secure && c_win && !ns_permit[c_idx]) |=> (rsp_rdata == 64'd0));
   assert_unimpl_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_win && !IMPL_MASK[c_idx]) |=> (rsp_rdata == 64'd0));
   assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (!c_win || c_misal)) |=> (rsp_rdata == 64'd0));

   genvar n;
   generate
      for (n = 0; n < NUM_SLOTS; n++) begin : g_lane
         assert_blocked_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_write && !req_secure && c_win && c_idx == 3'(n) && !ns_permit[n])
            |=> $stable(offset_out[64*n +: 64]));
         assert_virt_diff_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (virt_count_out[64*n +: 64] ==
                              $past(phys_count) - $past(offset_out[64*n +: 64])));
      end
   endgenerate
endmodule

bind tob_offset_bank tob_offset_bank_chk #(
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_SLOTS(NUM_SLOTS), .IMPL_MASK(IMPL_MASK)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_wide(req_wide), .req_secure(req_secure), .req_addr(req_addr),
   .ns_permit(ns_permit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .phys_count(phys_count), .offset_out(offset_out), .virt_count_out(virt_count_out)
);

// File: tb/tob_offset_bank_tb_top.sv
`timescale 1ns/1ps
module tob_offset_bank_tb_top;
   localparam int         NS   = 8;
   localparam logic [7:0] IMPL = 8'hBF;   // slot 6 absent

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_secure = 1'b0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [7:0]  req_wstrb = '0;
   logic [7:0]  ns_permit = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic [63:0] phys_count = '0;
   logic [64*NS-1:0] offset_out, virt_count_out;

   always #4 clk = ~clk;   // 125 MHz

   tob_offset_bank #(.NUM_SLOTS(NS), .IMPL_MASK(IMPL)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_secure(req_secure), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_wstrb(req_wstrb), .ns_permit(ns_permit),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .phys_count(phys_count),
      .offset_out(offset_out), .virt_count_out(virt_count_out)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [63:0] model [NS];
   logic [63:0] exp_q [$];
   string       tag_q [$];

   task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference behaviour built from the requirements.
   function automatic logic [63:0] model_do(bit wr, bit wide, bit sec, logic [11:0] a,
                                            logic [63:0] wd, logic [7:0] ws);
      bit ok;
      int s;
      logic [7:0]  ls;
      logic [63:0] ld;
      ok = (a >= 12'h080) && (a < 12'h0C0) && (wide ? a[2:0] == 3'd0 : a[1:0] == 2'd0);
      s  = int'(a[5:3]);
      if (ok && !IMPL[s]) ok = 1'b0;
      if (ok && !sec && !ns_permit[s]) ok = 1'b0;
      if (!ok) return 64'd0;
      if (wr) begin
         if (wide) begin ls = ws; ld = wd; end
         else begin
            ls = a[2] ? {ws[3:0], 4'h0} : {4'h0, ws[3:0]};
            ld = {wd[31:0], wd[31:0]};
         end
         for (int b = 0; b < 8; b++) if (ls[b]) model[s][8*b +: 8] = ld[8*b +: 8];
         return 64'd0;
      end
      if (wide) return model[s];
      return a[2] ? {32'd0, model[s][63:32]} : {32'd0, model[s][31:0]};
   endfunction

   task automatic do_req(string tag, bit wr, bit wide, bit sec, logic [11:0] a,
                         logic [63:0] wd, logic [7:0] ws);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_wide = wide; req_secure = sec;
      req_addr = a; req_wdata = wd; req_wstrb = ws;
      exp_q.push_back(model_do(wr, wide, sec, a, wd, ws));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wstrb = '0;
   endtask

   // Monitor: pop one expected item for each response.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11: actual=unexpected response expected=none");
         end else begin
            automatic logic [63:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check64(t, rsp_rdata, e);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check64("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
      check64("R11 reset rsp_rdata", rsp_rdata, 64'd0);
      rst_n = 1'b1;

      // R2 R4: secure wide writes then wide reads of every slot
      for (int n = 0; n < NS; n++)
         do_req("R2 R4 wide write", 1, 1, 1, 12'h080 + 12'(8*n),
                64'hA5C3_0000_1000_0F0F + 64'h0101_0202_0303_0404 * 64'(n), 8'hFF);
      for (int n = 0; n < NS; n++)
         do_req(n == 6 ? "R7 absent slot wide read" : "R2 R4 wide read",
                0, 1, 1, 12'h080 + 12'(8*n), 64'd0, 8'h00);
      // R1: narrow reads of slot 3
      do_req("R1 low word read",  0, 0, 1, 12'h098, 64'd0, 8'h0);
      do_req("R1 high word read", 0, 0, 1, 12'h09C, 64'd0, 8'h0);
      // R3: partial strobes
      do_req("R3 narrow upper strobe write", 1, 0, 1, 12'h094, 64'hFFFF_FFFF_1122_3344, 8'hF5);
      do_req("R3 readback after narrow strobe", 0, 1, 1, 12'h090, 64'd0, 8'h0);
      do_req("R3 wide strobe write", 1, 1, 1, 12'h088, 64'hDEAD_BEEF_CAFE_F00D, 8'h81);
      do_req("R3 readback after wide strobe", 0, 1, 1, 12'h088, 64'd0, 8'h0);
      idle();

      // R5 R6: non-secure permits
      ns_permit = 8'b0000_0101;
      do_req("R6 ns permitted read", 0, 1, 0, 12'h080, 64'd0, 8'h0);
      do_req("R5 ns blocked read",   0, 1, 0, 12'h088, 64'd0, 8'h0);
      do_req("R5 ns blocked write",  1, 1, 0, 12'h088, 64'h1234_5678_9ABC_DEF0, 8'hFF);
      do_req("R5 ns blocked narrow write", 1, 0, 0, 12'h08C, 64'h0000_0000_7777_7777, 8'hF);
      do_req("R5 secure readback of blocked slot", 0, 1, 1, 12'h088, 64'd0, 8'h0);
      do_req("R6 ns permitted write", 1, 0, 0, 12'h090, 64'h0000_0000_5566_7788, 8'hF);
      do_req("R6 readback of ns write", 0, 1, 1, 12'h090, 64'd0, 8'h0);

      // R8: outside window and misaligned
      do_req("R8 misaligned narrow write", 1, 0, 1, 12'h0A2, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF);
      do_req("R8 misaligned wide write",   1, 1, 1, 12'h0A4, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
      do_req("R8 misaligned wide read",    0, 1, 1, 12'h0A4, 64'd0, 8'h0);
      do_req("R8 past window read",        0, 0, 1, 12'h0C0, 64'd0, 8'h0);
      do_req("R8 below window read",       0, 0, 1, 12'h07C, 64'd0, 8'h0);
      do_req("R8 past window write",       1, 1, 1, 12'h0C0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
      do_req("R8 slot 4 intact",           0, 1, 1, 12'h0A0, 64'd0, 8'h0);
      // R7: absent slot
      do_req("R7 absent slot write", 1, 0, 1, 12'h0B0, 64'h0000_0000_FFFF_FFFF, 8'hF);
      do_req("R7 absent slot narrow read", 0, 0, 1, 12'h0B0, 64'd0, 8'h0);
      idle();
      idle();

      // R10 R7: parallel offset lanes
      for (int n = 0; n < NS; n++)
         check64(n == 6 ? "R7 absent lane zero" : "R10 offset lane", offset_out[64*n +: 64],
                 IMPL[n] ? model[n] : 64'd0);

      // R9: virtual count, including wrap when phys < offset
      phys_count = 64'h0000_0000_0000_0010;
      @(negedge clk);
      for (int n = 0; n < NS; n++)
         check64("R9 virtual count wrap", virt_count_out[64*n +: 64],
                 64'h10 - (IMPL[n] ? model[n] : 64'd0));
      phys_count = 64'hFFFF_0000_1234_5678;
      @(negedge clk);
      for (int n = 0; n < NS; n++)
         check64("R9 virtual count", virt_count_out[64*n +: 64],
                 64'hFFFF_0000_1234_5678 - (IMPL[n] ? model[n] : 64'd0));

      // R10: lane updates on the accepting edge
      do_req("R10 write slot 7", 1, 1, 1, 12'h0B8, 64'h0F0E_0D0C_0B0A_0908, 8'hFF);
      idle();
      check64("R10 lane after write", offset_out[64*7 +: 64], 64'h0F0E_0D0C_0B0A_0908);

      idle();
      check64("R11 queue drained", 64'(exp_q.size()), 64'd0);
      finish_run();
   end
endmodule